// File: doc/BRIEF.md
# Misaligned Load/Store Splitter

This block sits between a core's load/store path and a memory that is one word (four bytes) wide. It takes one access at a time: a byte address, a size code and, for stores, the data. It places each byte of the value at its memory address according to a byte order selected per access, drives word-aligned requests with byte enables, and returns zero-extended load data. A write touches only the byte lanes that belong to the access.

An access is misaligned when its address is not a multiple of its size. A per-access policy input decides what happens to such an access. In trap policy the block raises a one-cycle trap and sends nothing to memory. In split policy an access that crosses a word boundary becomes two word transactions, lower word first, and the two read words are merged into one result. A misaligned access that stays inside one word needs only one transaction.

Top module: `lsu_split_unit`

## Requirements
- R1: Size code 2'b00 accesses one byte, 2'b01 two bytes, 2'b10 four bytes; code 2'b11 is treated as four bytes.
- R2: An aligned access (address modulo size equal to zero) makes exactly one memory transaction at the word address with the two low bits cleared.
- R3: In split policy, an access whose bytes span two words makes two transactions: first the lower word address, then that address plus 4.
- R4: In trap policy, a misaligned access pulses trap_o in the cycle after acceptance, makes no memory transaction, writes nothing and gives no done_o.
- R5: With cfg_big_endian_i low, value byte i (bits 8i+7:8i) maps to address A+i.
- R6: With cfg_big_endian_i high, value byte i maps to address A+N-1-i, so the most significant byte sits at the lowest address.
- R7: Address a lives in byte lane a[1:0] of its word, bits 8*lane+7:8*lane of mem_wdata_o and mem_rdata_i. A store enables only the lanes of its own bytes in each transaction, and every other byte of memory keeps its value.
- R8: Load results are zero-extended above the accessed bytes; a store completes with rdata_o equal to zero.
- R9: done_o pulses for one cycle, exactly one cycle after the response of the final transaction, with rdata_o valid in that cycle.
- R10: req_ready_o is high after reset and low while a memory transaction is pending; mem_valid_o is low after reset.
- R11: While mem_valid_o is high and mem_ready_i low, the request (address, enables, data, write flag) holds stable.
- R12: In split policy, a misaligned access that lies within one word makes a single transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_big_endian_i | input | 1 | Byte order for the accepted access (1 = big-endian) |
| cfg_trap_i | input | 1 | Misalignment policy (1 = trap, 0 = split) |
| req_valid_i | input | 1 | Access request valid |
| req_ready_o | output | 1 | Block can accept an access |
| req_addr_i | input | AW | Byte address |
| req_size_i | input | 2 | Size code |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_wdata_i | input | 8*NB | Store value, least significant byte in bits 7:0 |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | AW | Word-aligned memory address |
| mem_write_o | output | 1 | Memory request is a write |
| mem_be_o | output | NB | Byte-lane enables |
| mem_wdata_o | output | 8*NB | Lane-steered write data |
| mem_rvalid_i | input | 1 | Memory response valid (read data or write acknowledge) |
| mem_rdata_i | input | 8*NB | Read word |
| done_o | output | 1 | Final response of an access has arrived |
| rdata_o | output | 8*NB | Load result |
| trap_o | output | 1 | Misalignment trap |

## Verification
A trap is due one clock after the accepting edge, and done_o one clock after the edge that sees the final memory response. Memory readiness is throttled pseudo-randomly, so these edges drift; the monitor records at each rising edge whether an acceptance or a response occurred and, on the falling edge where trap_o or done_o shows, requires that record to be set. Expected results, transaction counts and word addresses come from a byte-level model queued by the driver and are compared on that same falling edge.

// File: rtl/lsu_split_pkg.sv
package lsu_split_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ_LO  = 3'd1,
    ST_WAIT_LO = 3'd2,
    ST_REQ_HI  = 3'd3,
    ST_WAIT_HI = 3'd4
  } split_state_e;

  // size code to byte count; code 3 is an alias of the long access
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'b00:   size_bytes = 3'd1;
      2'b01:   size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/lsu_store_steer.sv
module lsu_store_steer #(
  parameter int NB = 4
) (
  input  logic [$clog2(NB)-1:0] off_i,
  input  logic [$clog2(NB):0]   nbytes_i,
  input  logic                  big_i,
  input  logic [8*NB-1:0]       wdata_i,
  output logic [16*NB-1:0]      win_data_o,
  output logic [2*NB-1:0]       win_be_o
);
  localparam int WW = $clog2(NB) + 1;

  logic [16*NB-1:0] part_d [NB];
  logic [2*NB-1:0]  part_e [NB];

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [WW-1:0] pos;
    logic          used;
    assign used = WW'(i) < nbytes_i;
    assign pos  = big_i ? WW'(off_i) + nbytes_i - WW'(1) - WW'(i)
                        : WW'(off_i) + WW'(i);
    always_comb begin
      part_d[i] = '0;
      part_e[i] = '0;
      if (used) begin
        part_d[i][pos*8 +: 8] = wdata_i[i*8 +: 8];
        part_e[i][pos]        = 1'b1;
      end
    end
  end

  always_comb begin
    win_data_o = '0;
    win_be_o   = '0;
    for (int k = 0; k < NB; k++) begin
      win_data_o = win_data_o | part_d[k];
      win_be_o   = win_be_o | part_e[k];
    end
  end

endmodule

// File: rtl/lsu_load_merge.sv
module lsu_load_merge #(
  parameter int NB = 4
) (
  input  logic [16*NB-1:0]      win_i,
  input  logic [$clog2(NB)-1:0] off_i,
  input  logic [$clog2(NB):0]   nbytes_i,
  input  logic                  big_i,
  output logic [8*NB-1:0]       value_o
);
  localparam int WW = $clog2(NB) + 1;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [WW-1:0] pos;
    assign pos = big_i ? WW'(off_i) + nbytes_i - WW'(1) - WW'(i)
                       : WW'(off_i) + WW'(i);
    // bytes above the access size read as zero
    assign value_o[i*8 +: 8] = (WW'(i) < nbytes_i) ? win_i[pos*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/lsu_split_fsm.sv
module lsu_split_fsm
  import lsu_split_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic two_i,
  input  logic mem_ready_i,
  input  logic mem_rvalid_i,
  output logic idle_o,
  output logic issue_o,
  output logic hi_o,
  output logic rsp_lo_o,
  output logic final_o
);
  split_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_REQ_LO;
      ST_REQ_LO:  if (mem_ready_i) state_d = ST_WAIT_LO;
      ST_WAIT_LO: if (mem_rvalid_i) state_d = two_i ? ST_REQ_HI : ST_IDLE;
      ST_REQ_HI:  if (mem_ready_i) state_d = ST_WAIT_HI;
      ST_WAIT_HI: if (mem_rvalid_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign idle_o   = state_q == ST_IDLE;
  assign issue_o  = (state_q == ST_REQ_LO) || (state_q == ST_REQ_HI);
  assign hi_o     = state_q == ST_REQ_HI;
  assign rsp_lo_o = (state_q == ST_WAIT_LO) && mem_rvalid_i;
  assign final_o  = mem_rvalid_i &&
                    (((state_q == ST_WAIT_LO) && !two_i) || (state_q == ST_WAIT_HI));

endmodule

// File: rtl/lsu_split_unit.sv
module lsu_split_unit
  import lsu_split_pkg::*;
#(
  parameter int AW = 32,
  parameter int NB = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_big_endian_i,
  input  logic            cfg_trap_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [1:0]      req_size_i,
  input  logic            req_write_i,
  input  logic [8*NB-1:0] req_wdata_i,
  output logic            mem_valid_o,
  input  logic            mem_ready_i,
  output logic [AW-1:0]   mem_addr_o,
  output logic            mem_write_o,
  output logic [NB-1:0]   mem_be_o,
  output logic [8*NB-1:0] mem_wdata_o,
  input  logic            mem_rvalid_i,
  input  logic [8*NB-1:0] mem_rdata_i,
  output logic            done_o,
  output logic [8*NB-1:0] rdata_o,
  output logic            trap_o
);
  localparam int DW = 8 * NB;
  localparam int OW = $clog2(NB);
  localparam int CW = OW + 1;
  localparam int SW = OW + 2;
  localparam int XW = AW - OW;

  // request decode
  logic [CW-1:0] in_nb;
  logic [OW-1:0] in_off;
  logic          in_misal, in_cross, accept, trap_hit, start;

  assign in_nb    = CW'(size_bytes(req_size_i));
  assign in_off   = req_addr_i[OW-1:0];
  assign in_misal = (in_off & OW'(in_nb - CW'(1))) != '0;
  assign in_cross = (SW'(in_off) + SW'(in_nb)) > SW'(NB);
  assign accept   = req_valid_i && req_ready_o;
  assign trap_hit = accept && in_misal && cfg_trap_i;
  assign start    = accept && !trap_hit;

  // latched access
  logic [XW-1:0] word_q;
  logic [OW-1:0] off_q;
  logic [CW-1:0] nb_q;
  logic          big_q, wr_q, two_q;
  logic [DW-1:0] wdata_q, lo_q, rdata_q;
  logic          done_q, trap_q;

  logic idle, issue, hi, rsp_lo, fin;

  lsu_split_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .two_i       (two_q),
    .mem_ready_i (mem_ready_i),
    .mem_rvalid_i(mem_rvalid_i),
    .idle_o      (idle),
    .issue_o     (issue),
    .hi_o        (hi),
    .rsp_lo_o    (rsp_lo),
    .final_o     (fin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      off_q   <= '0;
      nb_q    <= '0;
      big_q   <= 1'b0;
      wr_q    <= 1'b0;
      two_q   <= 1'b0;
      wdata_q <= '0;
    end else if (start) begin
      word_q  <= req_addr_i[AW-1:OW];
      off_q   <= in_off;
      nb_q    <= in_nb;
      big_q   <= cfg_big_endian_i;
      wr_q    <= req_write_i;
      two_q   <= in_cross;
      wdata_q <= req_wdata_i;
    end
  end

  // store steering over the two-word window
  logic [2*DW-1:0] win_data;
  logic [2*NB-1:0] win_be;

  lsu_store_steer #(.NB(NB)) u_steer (
    .off_i     (off_q),
    .nbytes_i  (nb_q),
    .big_i     (big_q),
    .wdata_i   (wdata_q),
    .win_data_o(win_data),
    .win_be_o  (win_be)
  );

  assign req_ready_o = idle;
  assign mem_valid_o = issue;
  assign mem_write_o = wr_q;
  assign mem_addr_o  = {word_q + XW'(hi), {OW{1'b0}}};
  assign mem_be_o    = hi ? win_be[2*NB-1:NB] : win_be[NB-1:0];
  assign mem_wdata_o = hi ? win_data[2*DW-1:DW] : win_data[DW-1:0];

  // load merge
  logic [2*DW-1:0] rd_win;
  logic [DW-1:0]   merged;

  assign rd_win = two_q ? {mem_rdata_i, lo_q} : {{DW{1'b0}}, mem_rdata_i};

  lsu_load_merge #(.NB(NB)) u_merge (
    .win_i   (rd_win),
    .off_i   (off_q),
    .nbytes_i(nb_q),
    .big_i   (big_q),
    .value_o (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      if (rsp_lo) lo_q <= mem_rdata_i;
      if (fin)    rdata_q <= wr_q ? '0 : merged;
      done_q <= fin;
      trap_q <= trap_hit;
    end
  end

  assign done_o  = done_q;
  assign rdata_o = rdata_q;
  assign trap_o  = trap_q;

endmodule

// File: rtl/lsu_split_unit_chk.sv
module lsu_split_unit_chk #(
  parameter int AW = 32,
  parameter int NB = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_ready_o,
  input logic            mem_valid_o,
  input logic            mem_ready_i,
  input logic [AW-1:0]   mem_addr_o,
  input logic            mem_write_o,
  input logic [NB-1:0]   mem_be_o,
  input logic [8*NB-1:0] mem_wdata_o,
  input logic            mem_rvalid_i,
  input logic            done_o,
  input logic            trap_o
);

  a_r11_hold_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) &&
      $stable(mem_be_o) && $stable(mem_wdata_o) && $stable(mem_write_o)));

  a_r10_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !req_ready_o);

  a_r9_done_follows_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_rvalid_i));

  a_r4_trap_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (!done_o && !mem_valid_o));

  a_r7_lanes_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_be_o != '0));

  a_r9_single_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, trap_o}));

endmodule

bind lsu_split_unit lsu_split_unit_chk #(.AW(AW), .NB(NB)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .mem_write_o (mem_write_o),
  .mem_be_o    (mem_be_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rvalid_i(mem_rvalid_i),
  .done_o      (done_o),
  .trap_o      (trap_o)
);

// File: tb/lsu_split_unit_test.sv
`timescale 1ns/1ps
module lsu_split_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_big = 1'b0, cfg_trap = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic        req_ready, mem_valid, mem_write, done, trap;
  logic [31:0] mem_addr, mem_wdata, rdata;
  logic [3:0]  mem_be;
  logic        mem_ready, mem_rvalid;
  logic [31:0] mem_rdata;

  always #2.5 clk = ~clk;

  lsu_split_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_big_endian_i(cfg_big), .cfg_trap_i(cfg_trap),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_size_i(req_size),
    .req_write_i(req_write), .req_wdata_i(req_wdata),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_addr_o(mem_addr), .mem_write_o(mem_write),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .rdata_o(rdata), .trap_o(trap)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7 + 3);
  endfunction

  // memory model: lane = addr[1:0]
  logic [31:0] words [16];
  logic [15:0] lfsr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ready  <= 1'b0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      lfsr       <= 16'hace1;
      for (int k = 0; k < 16; k++)
        words[k] <= {pat(4*k+3), pat(4*k+2), pat(4*k+1), pat(4*k)};
    end else begin
      lfsr       <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready  <= lfsr[0] | lfsr[3];
      mem_rvalid <= 1'b0;
      if (mem_valid && mem_ready) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= words[mem_addr[5:2]];
        if (mem_write)
          for (int k = 0; k < 4; k++)
            if (mem_be[k]) words[mem_addr[5:2]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
      end
    end
  end

  // golden byte model and scoreboard
  logic [7:0] gold [64];
  initial for (int a = 0; a < 64; a++) gold[a] = pat(a);

  typedef struct {
    bit          is_trap;
    logic [31:0] rdata;
    int          ntr;
    logic [31:0] a0;
    string       tag;
  } exp_t;
  exp_t exq [$];

  task automatic access(input int addr, input logic [1:0] sz, input bit wr,
                        input logic [31:0] wd, input bit big, input bit trapm,
                        input string tag);
    exp_t e;
    int n;
    n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    e.tag = tag;
    e.a0 = 32'(addr & ~3);
    e.rdata = '0;
    if (trapm && (addr % n) != 0) begin
      e.is_trap = 1'b1;
      e.ntr = 0;
    end else begin
      e.is_trap = 1'b0;
      e.ntr = ((addr % 4) + n > 4) ? 2 : 1;
      for (int i = 0; i < n; i++) begin
        int p;
        p = big ? addr + n - 1 - i : addr + i;
        if (wr) gold[p] = wd[i*8 +: 8];
        else    e.rdata[i*8 +: 8] = gold[p];
      end
    end
    exq.push_back(e);
    @(negedge clk);
    req_addr = 32'(addr); req_size = sz; req_write = wr; req_wdata = wd;
    cfg_big = big; cfg_trap = trapm; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  logic        acc_seen = 1'b0, rv_seen = 1'b0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;
  logic [3:0]  prev_be = '0;
  int          ntr = 0;
  logic [31:0] addr0 = '0, addr1 = '0;

  always @(posedge clk) begin
    acc_seen <= req_valid && req_ready;
    rv_seen  <= mem_rvalid;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      if (prev_stall)
        chk(mem_valid && mem_addr == prev_addr && mem_be == prev_be,
            "R11", "request held during stall", mem_addr, prev_addr);
      if (mem_valid && mem_ready) begin
        chk(!req_ready, "R10", "not ready while busy", 32'(req_ready), 0);
        if (ntr == 0) addr0 = mem_addr;
        else if (ntr == 1) addr1 = mem_addr;
        ntr++;
      end
      if (done || trap) begin
        if (exq.size() == 0) begin
          chk(1'b0, "R9", "unexpected completion", 32'(done), 0);
        end else begin
          e = exq.pop_front();
          chk(trap == e.is_trap, e.tag, "completion kind", 32'(trap), 32'(e.is_trap));
          if (e.is_trap) begin
            chk(acc_seen, "R4", "trap one cycle after accept", 32'(acc_seen), 1);
          end else begin
            chk(rdata == e.rdata, e.tag, "result", rdata, e.rdata);
            chk(rv_seen, "R9", "done one cycle after final response", 32'(rv_seen), 1);
          end
          chk(ntr == e.ntr, e.tag, "transaction count", 32'(ntr), 32'(e.ntr));
          if (e.ntr >= 1) chk(addr0 == e.a0, e.tag, "first word address", addr0, e.a0);
          if (e.ntr == 2) chk(addr1 == e.a0 + 4, "R3", "second word address", addr1, e.a0 + 4);
        end
        ntr = 0;
      end
      prev_stall = mem_valid && !mem_ready;
      prev_addr  = mem_addr;
      prev_be    = mem_be;
    end
  end

  task automatic run_tests;
    // reset state
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready in reset", 32'(req_ready), 1);
    chk(mem_valid == 1'b0, "R10", "no request in reset", 32'(mem_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready after reset", 32'(req_ready), 1);
    chk(done == 1'b0 && trap == 1'b0, "R9", "quiet after reset", 32'({done, trap}), 0);
    chk(mem_valid == 1'b0, "R10", "idle after reset", 32'(mem_valid), 0);

    // aligned loads, both orders
    access(8, 2'b10, 0, 0, 0, 0, "R5");
    access(8, 2'b10, 0, 0, 1, 0, "R6");
    access(5, 2'b00, 0, 0, 0, 0, "R2");
    access(6, 2'b01, 0, 0, 0, 0, "R5");
    access(6, 2'b01, 0, 0, 1, 0, "R6");
    access(12, 2'b11, 0, 0, 0, 0, "R1");
    access(12, 2'b11, 0, 0, 1, 0, "R1");
    // crossing loads in split policy
    access(2, 2'b10, 0, 0, 0, 0, "R3");
    access(2, 2'b10, 0, 0, 1, 0, "R3");
    access(7, 2'b01, 0, 0, 1, 0, "R3");
    access(13, 2'b10, 0, 0, 0, 0, "R3");
    // misaligned within one word
    access(1, 2'b01, 0, 0, 0, 0, "R12");
    access(9, 2'b01, 0, 0, 1, 0, "R12");
    // stores, neighbours read back through loads
    access(13, 2'b10, 1, 32'h11223344, 0, 0, "R7");
    access(12, 2'b10, 0, 0, 0, 0, "R7");
    access(16, 2'b10, 0, 0, 0, 0, "R7");
    access(23, 2'b01, 1, 32'h0000a5c3, 1, 0, "R7");
    access(20, 2'b10, 0, 0, 0, 0, "R7");
    access(24, 2'b10, 0, 0, 0, 0, "R7");
    access(30, 2'b00, 1, 32'h0000007e, 0, 0, "R7");
    access(28, 2'b10, 0, 0, 0, 0, "R8");
    // value 515 in both orders, read bytewise
    access(40, 2'b10, 1, 32'd515, 1, 0, "R6");
    for (int a = 40; a < 44; a++) access(a, 2'b00, 0, 0, 0, 0, "R6");
    access(44, 2'b10, 1, 32'd515, 0, 0, "R5");
    for (int a = 44; a < 48; a++) access(a, 2'b00, 0, 0, 0, 0, "R5");
    // trap policy
    access(2, 2'b10, 0, 0, 0, 1, "R4");
    access(5, 2'b01, 0, 0, 1, 1, "R4");
    access(50, 2'b10, 1, 32'hdeadbeef, 0, 1, "R4");
    access(48, 2'b10, 0, 0, 0, 0, "R4");
    access(52, 2'b10, 0, 0, 0, 0, "R4");
    access(8, 2'b10, 0, 0, 0, 1, "R2");
    access(7, 2'b00, 0, 0, 1, 1, "R2");
    access(3, 2'b11, 0, 0, 0, 1, "R1");
    // sweeps of offset, size and order
    for (int off = 0; off < 8; off++)
      for (int sz = 0; sz < 3; sz++)
        for (int b = 0; b < 2; b++)
          access(16 + off, 2'(sz), 0, 0, b[0], 0, "R8");
    for (int off = 0; off < 8; off++)
      for (int sz = 0; sz < 3; sz++)
        access(32 + off, 2'(sz), 1, 32'h9a000000 | 32'(off * 37 + sz), off[0], 0, "R7");
    for (int w = 28; w < 44; w += 4) access(w, 2'b10, 0, 0, 0, 0, "R7");
    while (exq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    bit wd_hit = 1'b0;
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) chk(1'b0, "R9", "watchdog expired", 0, 1);
    chk(exq.size() == 0, "R9", "pending completions", 32'(exq.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule